// File: doc/BRIEF.md
# Transmit Frame Buffer with Threshold or Whole-Frame Release

This block sits on the transmit path between a DMA engine that writes frame data and a MAC that reads it. It holds 2 KB of frame data as 32-bit words. Each stored word carries a start-of-frame marker and an end-of-frame marker. The block counts how many complete frames it holds, and it uses that count to decide when the MAC side may begin reading a new frame.

Two release policies are available. In threshold mode a frame is offered to the MAC as soon as the stored fill level reaches a programmed value. A frame that is already complete is offered even if it is below that value. In whole-frame mode a frame is offered only after its end marker is stored. An enable bit gates the start of new frames, and a frame already in progress always runs to its end. Two conditions are handled so that the path cannot stall. If the buffer runs dry in the middle of a frame, an underflow pulse is raised and the rest of that frame is thrown away. If a frame is too large to fit in the buffer, it is released as if threshold mode were selected. Checksum insertion is permitted only when whole-frame mode is selected.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset, `rd_valid`, `underflow` and `frame_cnt` are zero, and `wr_ready` is one.
- R2: The words offered on the read side match the written words in the same order, with `data`, the start marker and the end marker all intact.
- R3: In threshold mode (`cfg_sf_mode`=0), `cfg_thr` code n sets a threshold of (n+1)*64 bytes, which is (n+1)*16 words. No frame is offered while fewer words are stored. The first word is offered in the cycle after the write that reaches the threshold.
- R4: In threshold mode, a frame whose end marker is stored is offered even when the stored level is below the threshold.
- R5: In whole-frame mode (`cfg_sf_mode`=1), a frame is not offered until its end marker is stored, whatever the fill level.
- R6: `frame_cnt` goes up by one for each accepted write that carries an end marker. It goes down by one for each end-marked word that leaves the buffer, whether it is read or discarded.
- R7: While `cfg_run` is 0, no new frame is offered. A frame whose first word has already been read continues to its end marker.
- R8: If the MAC asserts `rd_ready` during a started frame while the buffer is empty, `underflow` is high for that one cycle. Every later word of that frame, up to and including its end marker, is discarded without being offered.
- R9: `wr_ready` is 0 when all 512 words are in use. In whole-frame mode, a full buffer that holds no complete frame releases its head frame so that the path cannot deadlock.
- R10: `csum_en` is 1 only when `cfg_csum_req` and `cfg_sf_mode` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sf_mode | input | 1 | 1 selects whole-frame release, 0 selects threshold release |
| cfg_thr | input | 2 | Threshold code n, giving (n+1)*64 bytes |
| cfg_run | input | 1 | Enables the start of new frames |
| cfg_csum_req | input | 1 | Software request for checksum insertion |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | 32 | Write data |
| wr_sof | input | 1 | Word is the first of its frame |
| wr_eof | input | 1 | Word is the last of its frame |
| rd_valid | output | 1 | A word is offered to the MAC |
| rd_ready | input | 1 | MAC takes the offered word |
| rd_data | output | 32 | Offered data |
| rd_sof | output | 1 | Offered word starts a frame |
| rd_eof | output | 1 | Offered word ends a frame |
| underflow | output | 1 | One-cycle pulse when the buffer runs dry inside a frame |
| frame_cnt | output | 10 | Number of complete frames stored |
| csum_en | output | 1 | Checksum insertion is permitted |

## Verification
Partial frames are written in threshold mode with two threshold codes, one word below and exactly at each level. This separates a correct threshold from one that is off by one or ignores the code. The same long partial frame in whole-frame mode shows that the level alone never releases a frame there. A short complete frame in threshold mode shows that completion alone is enough. Three back-to-back frames, a stop raised partway through a frame, a frame starved mid-way, and a frame larger than the buffer each exercise one distinct path: frame counting, stop handling, flushing, and the deadlock escape.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_ACTIVE = 2'd1,
    RD_FLUSH  = 2'd2
  } rd_state_e;

  // Threshold in words: code n selects (n+1)*64 bytes.
  function automatic int thr_words(input logic [1:0] code, input int bytes_per_word);
    return ((int'(code) + 1) * 64) / bytes_per_word;
  endfunction

endpackage

// File: rtl/tx_fifo_ram.sv
module tx_fifo_ram #(
  parameter int EW    = 34,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tx_fifo_track.sv
module tx_fifo_track #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_eof,
  input  logic          pop,
  input  logic          pop_eof,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] level,
  output logic [CW-1:0] frame_cnt,
  output logic          full,
  output logic          empty
);
  logic fr_inc, fr_dec;
  assign fr_inc = push && push_eof;
  assign fr_dec = pop && pop_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      frame_cnt <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      case ({fr_inc, fr_dec})
        2'b10:   frame_cnt <= frame_cnt + 1'b1;
        2'b01:   frame_cnt <= frame_cnt - 1'b1;
        default: frame_cnt <= frame_cnt;
      endcase
    end
  end

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/tx_fifo_rdctl.sv
module tx_fifo_rdctl
  import tx_fifo_pkg::*;
#(
  parameter int CW  = 10,
  parameter int BPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sf_mode,
  input  logic [1:0]    cfg_thr,
  input  logic          cfg_run,
  input  logic          rd_ready,
  input  logic          empty,
  input  logic          full,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] frame_cnt,
  input  logic          head_eof,
  output logic          rd_valid,
  output logic          pop,
  output logic          underflow,
  output logic          release_ok,
  output rd_state_e     state
);
  rd_state_e  state_nx;
  logic [CW-1:0] thr_lvl;
  logic          take;

  assign thr_lvl = CW'(thr_words(cfg_thr, BPW));

  // A full buffer without a complete frame is released to avoid deadlock.
  assign release_ok = cfg_run && !empty &&
                      ((frame_cnt != '0) || full || (!cfg_sf_mode && level >= thr_lvl));

  assign rd_valid  = !empty && ((state == RD_ACTIVE) || (state == RD_IDLE && release_ok));
  assign take      = rd_valid && rd_ready;
  assign underflow = (state == RD_ACTIVE) && empty && rd_ready;
  assign pop       = take || ((state == RD_FLUSH) && !empty);

  always_comb begin
    state_nx = state;
    case (state)
      RD_IDLE:   if (take && !head_eof) state_nx = RD_ACTIVE;
      RD_ACTIVE: if (underflow) state_nx = RD_FLUSH;
                 else if (take && head_eof) state_nx = RD_IDLE;
      RD_FLUSH:  if (pop && head_eof) state_nx = RD_IDLE;
      default:   state_nx = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RD_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tx_fifo_pkg::*;
#(
  parameter int DW          = 32,
  parameter int DEPTH_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sf_mode,
  input  logic [1:0]    cfg_thr,
  input  logic          cfg_run,
  input  logic          cfg_csum_req,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sof,
  input  logic          wr_eof,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_sof,
  output logic          rd_eof,
  output logic          underflow,
  output logic [$clog2(DEPTH_BYTES/(DW/8)+1)-1:0] frame_cnt,
  output logic          csum_en
);
  localparam int BPW   = DW / 8;
  localparam int DEPTH = DEPTH_BYTES / BPW;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int EW    = DW + 2;

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] level;
  logic          full, empty, push, pop, release_ok;
  logic [EW-1:0] head;
  rd_state_e     rd_state;

  assign wr_ready = !full;
  assign push     = wr_valid && !full;
  assign rd_data  = head[DW-1:0];
  assign rd_eof   = head[DW];
  assign rd_sof   = head[DW+1];
  assign csum_en  = cfg_csum_req && cfg_sf_mode;

  tx_fifo_ram #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(push), .waddr(wptr), .wdata({wr_sof, wr_eof, wr_data}),
    .raddr(rptr), .rdata(head)
  );

  tx_fifo_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .push(push), .push_eof(wr_eof),
    .pop(pop), .pop_eof(head[DW]), .wptr(wptr), .rptr(rptr),
    .level(level), .frame_cnt(frame_cnt), .full(full), .empty(empty)
  );

  tx_fifo_rdctl #(.CW(CW), .BPW(BPW)) u_rdctl (
    .clk(clk), .rst_n(rst_n), .cfg_sf_mode(cfg_sf_mode), .cfg_thr(cfg_thr),
    .cfg_run(cfg_run), .rd_ready(rd_ready), .empty(empty), .full(full),
    .level(level), .frame_cnt(frame_cnt), .head_eof(head[DW]),
    .rd_valid(rd_valid), .pop(pop), .underflow(underflow),
    .release_ok(release_ok), .state(rd_state)
  );
endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk
  import tx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_sf_mode,
  input logic          cfg_run,
  input logic          cfg_csum_req,
  input logic          rd_valid,
  input logic          wr_ready,
  input logic          underflow,
  input logic          csum_en,
  input logic          full,
  input logic [CW-1:0] level,
  input logic [CW-1:0] frame_cnt,
  input rd_state_e     rd_state
);
  // R2: nothing is offered from an empty store
  p_no_read_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (level != '0));

  // R9: occupancy stays within capacity
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R9: writer is held back when all words are in use
  p_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH)) |-> !wr_ready);

  // R5: whole-frame mode holds a partial frame unless the buffer is full
  p_sf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sf_mode && rd_state == RD_IDLE && frame_cnt == '0 && !full) |-> !rd_valid);

  // R7: stopped, no new frame starts
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && rd_state == RD_IDLE) |-> !rd_valid);

  // R8: after underflow nothing is offered in the next cycle
  p_flush_after_uf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !rd_valid);

  // R6: frame count moves by at most one per cycle
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == $past(frame_cnt)) || (frame_cnt == $past(frame_cnt) + 1'b1) ||
    (frame_cnt == $past(frame_cnt) - 1'b1));

  // R10: checksum insertion only in whole-frame mode
  p_csum_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csum_en |-> (cfg_sf_mode && cfg_csum_req));
endmodule

bind tx_frame_fifo tx_frame_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sf_mode(cfg_sf_mode), .cfg_run(cfg_run),
  .cfg_csum_req(cfg_csum_req), .rd_valid(rd_valid), .wr_ready(wr_ready),
  .underflow(underflow), .csum_en(csum_en), .full(full), .level(level),
  .frame_cnt(frame_cnt), .rd_state(rd_state)
);

// File: tb/tx_frame_fifo_tb.sv
module tx_frame_fifo_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_sf_mode = 0, cfg_run = 0, cfg_csum_req = 0;
  logic [1:0]  cfg_thr = 0;
  logic        wr_valid = 0, wr_sof = 0, wr_eof = 0, rd_ready = 0;
  logic [31:0] wr_data = 0;
  logic        wr_ready, rd_valid, rd_sof, rd_eof, underflow, csum_en;
  logic [31:0] rd_data;
  logic [9:0]  frame_cnt;

  int n_chk = 0, n_bad = 0;
  logic [33:0] exp_q[$];
  logic [31:0] seq = 32'hA000_0000;

  always #5 clk = ~clk;

  tx_frame_fifo u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare every handshake against the queue
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected word", int'(rd_data), 0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check({rd_sof, rd_eof, rd_data} == e, "R2 word order/markers",
              int'({rd_sof, rd_eof, rd_data[15:0]}), int'({e[33:32], e[15:0]}));
      end
    end
  end

  task automatic wr_word(input bit sof, input bit eof, input bit keep);
    wr_valid = 1; wr_sof = sof; wr_eof = eof; wr_data = seq;
    if (keep) exp_q.push_back({sof, eof, seq});
    seq++;
    @(posedge clk); #1;
    wr_valid = 0; wr_sof = 0; wr_eof = 0;
  endtask

  task automatic wr_frame(input int n, input bit keep);
    for (int i = 0; i < n; i++) wr_word(i == 0, i == n - 1, keep);
  endtask

  task automatic rd_words(input int n);
    int got = 0;
    rd_ready = 1;
    while (got < n) begin
      @(negedge clk);
      if (rd_valid) got++;
      @(posedge clk); #1;
    end
    rd_ready = 0;
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check(rd_valid == 0 && frame_cnt == 0 && underflow == 0 && wr_ready == 1,
          "R1 reset state", int'({rd_valid, underflow, wr_ready}), 1);
    rst_n = 1;
    @(posedge clk); #1;

    // R3: threshold code 0 -> 16 words
    cfg_run = 1; cfg_sf_mode = 0; cfg_thr = 0;
    for (int i = 0; i < 15; i++) wr_word(i == 0, 0, 1);
    @(negedge clk); check(rd_valid == 0, "R3 below thr 16", rd_valid, 0);
    @(posedge clk); #1;
    wr_word(0, 0, 1);
    @(negedge clk); check(rd_valid == 1, "R3 at thr 16", rd_valid, 1);
    @(posedge clk); #1;
    wr_word(0, 1, 1);
    rd_words(17);

    // R3: threshold code 1 -> 32 words
    cfg_thr = 1;
    for (int i = 0; i < 31; i++) wr_word(i == 0, 0, 1);
    @(negedge clk); check(rd_valid == 0, "R3 below thr 32", rd_valid, 0);
    @(posedge clk); #1;
    wr_word(0, 0, 1);
    @(negedge clk); check(rd_valid == 1, "R3 at thr 32", rd_valid, 1);
    @(posedge clk); #1;
    wr_word(0, 1, 1);
    rd_words(33);

    // R4: short complete frame below threshold
    cfg_thr = 3;
    wr_frame(3, 1);
    @(negedge clk); check(rd_valid == 1, "R4 short frame released", rd_valid, 1);
    @(posedge clk); #1;
    rd_words(3);

    // R5: whole-frame mode holds a long partial frame
    cfg_sf_mode = 1; cfg_thr = 0;
    for (int i = 0; i < 40; i++) wr_word(i == 0, 0, 1);
    @(negedge clk); check(rd_valid == 0, "R5 partial held", rd_valid, 0);
    @(posedge clk); #1;
    wr_word(0, 1, 1);
    @(negedge clk);
    check(rd_valid == 1, "R5 released at eof", rd_valid, 1);
    check(frame_cnt == 1, "R6 count after eof", int'(frame_cnt), 1);
    @(posedge clk); #1;
    rd_words(41);
    @(negedge clk); check(frame_cnt == 0, "R6 count after read", int'(frame_cnt), 0);
    @(posedge clk); #1;

    // R6: three frames stored
    wr_frame(2, 1); wr_frame(3, 1); wr_frame(1, 1);
    @(negedge clk); check(frame_cnt == 3, "R6 three frames", int'(frame_cnt), 3);
    @(posedge clk); #1;
    rd_words(2);
    @(negedge clk); check(frame_cnt == 2, "R6 one read", int'(frame_cnt), 2);
    @(posedge clk); #1;
    rd_words(4);

    // R10: checksum gate
    cfg_csum_req = 1; #1;
    check(csum_en == 1, "R10 sf+req", csum_en, 1);
    cfg_sf_mode = 0; #1;
    check(csum_en == 0, "R10 threshold blocks", csum_en, 0);
    cfg_sf_mode = 1; cfg_csum_req = 0; #1;
    check(csum_en == 0, "R10 no req", csum_en, 0);

    // R7: stop blocks new frames, finishes current one
    cfg_run = 0;
    wr_frame(4, 1);
    @(negedge clk); check(rd_valid == 0, "R7 stopped hold", rd_valid, 0);
    @(posedge clk); #1;
    cfg_run = 1;
    wr_frame(3, 1);
    rd_words(2);
    cfg_run = 0;
    rd_words(2);
    @(negedge clk);
    check(rd_valid == 0 && frame_cnt == 1, "R7 next frame held", int'({rd_valid, frame_cnt}), 1);
    @(posedge clk); #1;
    cfg_run = 1;
    rd_words(3);

    // R8: underflow and flush in threshold mode
    cfg_sf_mode = 0; cfg_thr = 0;
    for (int i = 0; i < 16; i++) wr_word(i == 0, 0, 1);
    rd_words(16);
    rd_ready = 1;
    @(negedge clk);
    check(underflow == 1, "R8 underflow pulse", underflow, 1);
    @(posedge clk); #1;
    rd_ready = 0;
    @(negedge clk); check(underflow == 0, "R8 pulse one cycle", underflow, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) wr_word(0, i == 3, 0);
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check(rd_valid == 0 && frame_cnt == 0, "R8 tail flushed", int'({rd_valid, frame_cnt}), 0);
    @(posedge clk); #1;
    wr_frame(2, 1);
    rd_words(2);

    // R9: oversize frame in whole-frame mode
    cfg_sf_mode = 1;
    for (int i = 0; i < 511; i++) wr_word(i == 0, 0, 1);
    @(negedge clk); check(rd_valid == 0, "R9 held before full", rd_valid, 0);
    @(posedge clk); #1;
    wr_word(0, 0, 1);
    @(negedge clk);
    check(wr_ready == 0, "R9 full blocks writes", wr_ready, 0);
    check(rd_valid == 1, "R9 forced release", rd_valid, 1);
    @(posedge clk); #1;
    rd_words(512);
    wr_word(0, 1, 1);
    rd_words(1);
    @(negedge clk);
    check(frame_cnt == 0 && exp_q.size() == 0, "R2 all consumed", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule